// File: doc/BRIEF.md
# Multi-Pool Rename Resource Tracker

This block keeps occupancy counts for several rename register pools that sit side by side in an out-of-order front end. Every architectural register is configured with a pool membership mask and an entry cost. Pool 0 is the unified pool and always includes every register. The other pools are meant to be disjoint subsets. Each pool has a configurable capacity, and a capacity of zero means the pool is unbounded.

The dispatch logic presents the destination registers of one instruction on the query port. It receives, in the same cycle, a mask with one bit per pool, where a set bit means that pool cannot take the request. When an instruction renames a destination, an allocate request charges the register's cost to every pool in its mask. When the write is retired, a release request refunds the same amounts. The block stores only configuration and counts. It holds no values, register indices or free lists.

Top module: `rename_pool_tracker`

## Requirements
- R1: After reset, every pool count is zero and every capacity is zero (unbounded). The underflow flag is clear, and every register belongs to pool 0 only, with a cost of 1.
- R2: A pool whose capacity is zero never reports full. Its count saturates at 2^CNT_W-1.
- R3: An allocate request is granted exactly when, for every pool in the register's mask, the count after any same-cycle release plus the register's cost does not exceed a nonzero capacity. A granted request adds the cost to each of those pools on the next clock edge. A bounded pool's count never exceeds its capacity.
- R4: Bit 0 of a configured membership mask is forced to 1, so every register is charged to pool 0.
- R5: A release request subtracts the register's cost from every pool in its mask on the next clock edge.
- R6: qry_full bit p is 1 exactly when capacity p is nonzero and count p plus the summed costs of the valid query slots whose register is in pool p exceeds capacity p. Bit p stands for pool p, and the output is combinational. With no valid slot, the mask is all zeros.
- R7: When allocate and release occur in the same cycle, the release is applied first and the allocation is judged against the reduced count.
- R8: A release larger than a pool's count leaves that count at zero and sets err_underflow. The flag stays set until reset.
- R9: A refused allocate (alloc_grant low in that cycle) changes no count.
- R10: used_cnt carries pool p's count in bits [p*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reg_we | input | 1 | Write the membership and cost of one register |
| cfg_reg_idx | input | RW | Register being configured |
| cfg_reg_mask | input | NUM_POOLS | Membership mask, bit p = pool p |
| cfg_reg_cost | input | COST_W | Entries charged per pool |
| cfg_cap_we | input | 1 | Write one pool capacity |
| cfg_cap_idx | input | PW | Pool being configured |
| cfg_cap_val | input | CNT_W | Capacity, zero = unbounded |
| qry_valid | input | DST_SLOTS | Valid bit per query slot |
| qry_reg | input | DST_SLOTS x RW | Destination register per slot |
| qry_full | output | NUM_POOLS | Per-pool shortage mask |
| alloc_valid | input | 1 | Allocate request |
| alloc_reg | input | RW | Register to allocate for |
| alloc_grant | output | 1 | Allocate accepted this cycle |
| rel_valid | input | 1 | Release request |
| rel_reg | input | RW | Register whose entries are returned |
| used_cnt | output | NUM_POOLS x CNT_W | Per-pool in-use counts |
| err_underflow | output | 1 | Sticky release-underflow flag |

## Verification
The capacity check inside each counter assumes that no capacity is lowered below its pool's current count while the block is in use. The hold check for refused requests assumes that configuration writes never alter counts. The bench writes every register and capacity before traffic starts. Its only later capacity change switches pool 0 to unbounded, which cannot violate the capacity bound. Releases are drawn freely, so underflow does occur, and the bench's model predicts it rather than avoiding it.

// File: rtl/rpt_pkg.sv
// Shared constants for the rename pool tracker.
// Assumes at most four pools, as the response mask is kept narrow.
package rpt_pkg;
    localparam int MAX_POOLS = 4;

    // Width needed to index n items, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rpt_cfg_table.sv
// Configuration store: per-register membership mask and cost, per-pool capacity.
// Assumes writes happen before traffic; writes to out-of-range indices are dropped.
module rpt_cfg_table #(
    parameter int NP     = 3,
    parameter int NR     = 16,
    parameter int COST_W = 2,
    parameter int CNT_W  = 6,
    parameter int RW     = rpt_pkg::idx_w(NR),
    parameter int PW     = rpt_pkg::idx_w(NP)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [RW-1:0]                reg_idx,
    input  logic [NP-1:0]                reg_mask,
    input  logic [COST_W-1:0]            reg_cost,
    input  logic                         cap_we,
    input  logic [PW-1:0]                cap_idx,
    input  logic [CNT_W-1:0]             cap_val,
    output logic [NR-1:0][NP-1:0]        mask_tab,
    output logic [NR-1:0][COST_W-1:0]    cost_tab,
    output logic [NP-1:0][CNT_W-1:0]     cap_tab
);
    // Register table: reset to pool-0-only, cost 1; pool 0 bit always forced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                mask_tab[i] <= NP'(1);
                cost_tab[i] <= COST_W'(1);
            end
        end else if (reg_we && int'(reg_idx) < NR) begin
            mask_tab[reg_idx] <= reg_mask | NP'(1);
            cost_tab[reg_idx] <= reg_cost;
        end
    end

    // Capacity table: reset to zero, meaning unbounded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_tab <= '0;
        end else if (cap_we && int'(cap_idx) < NP) begin
            cap_tab[cap_idx] <= cap_val;
        end
    end
endmodule

// File: rtl/rpt_pool_ctr.sv
// One pool's in-use counter. Release is applied before allocation.
// Underflow clamps at zero; unbounded pools (cap 0) clamp at all-ones.
// Assumes COST_W <= CNT_W and that cap is not lowered below the count.
module rpt_pool_ctr #(
    parameter int CNT_W  = 6,
    parameter int COST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cap,
    input  logic [COST_W-1:0] rel_amt,
    input  logic [COST_W-1:0] alloc_amt,
    input  logic              alloc_do,
    output logic [CNT_W-1:0]  used,
    output logic              fits,
    output logic              underflow
);
    localparam int SW = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] rel_ext;
    logic [CNT_W-1:0] after_rel;
    logic [SW-1:0]    sum;

    // Release first, clamped at zero, then form the tentative allocation.
    always_comb begin
        rel_ext   = CNT_W'(rel_amt);
        underflow = rel_ext > used;
        after_rel = underflow ? '0 : used - rel_ext;
        sum       = {1'b0, after_rel} + SW'(alloc_amt);
        fits      = (cap == '0) || (sum <= {1'b0, cap});
    end

    // Count register: saturating update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (alloc_do) begin
            used <= (sum > {1'b0, CNT_MAX}) ? CNT_MAX : sum[CNT_W-1:0];
        end else begin
            used <= after_rel;
        end
    end

    assert_within_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap != '0) |-> (used <= cap));

    assert_grant_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_do |-> fits);
endmodule

// File: rtl/rpt_query.sv
// Availability query: per pool, sums the cost of valid destination slots
// that fall in the pool and flags a shortage against a nonzero capacity.
// Purely combinational; counts are the registered ones.
module rpt_query #(
    parameter int NP     = 3,
    parameter int NR     = 16,
    parameter int ND     = 2,
    parameter int COST_W = 2,
    parameter int CNT_W  = 6,
    parameter int RW     = rpt_pkg::idx_w(NR)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ND-1:0]              qry_valid,
    input  logic [ND-1:0][RW-1:0]      qry_reg,
    input  logic [NR-1:0][NP-1:0]      mask_tab,
    input  logic [NR-1:0][COST_W-1:0]  cost_tab,
    input  logic [NP-1:0][CNT_W-1:0]   cap_tab,
    input  logic [NP-1:0][CNT_W-1:0]   used,
    output logic [NP-1:0]              full
);
    localparam int DW = CNT_W + COST_W + $clog2(ND + 1) + 1;

    for (genvar p = 0; p < NP; p++) begin : g_pool
        logic [DW-1:0] demand;

        // Sum the costs this instruction would place on pool p.
        always_comb begin
            demand = '0;
            for (int d = 0; d < ND; d++) begin
                if (qry_valid[d] && mask_tab[qry_reg[d]][p])
                    demand = demand + DW'(cost_tab[qry_reg[d]]);
            end
        end

        assign full[p] = (cap_tab[p] != '0) &&
                         ((DW'(used[p]) + demand) > DW'(cap_tab[p]));

        assert_unbounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_tab[p] == '0) |-> !full[p]);
    end

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid == '0) |-> (full == '0));
endmodule

// File: rtl/rename_pool_tracker.sv
// Top of the rename pool tracker. Routes per-register cost into each pool
// counter, grants an allocation only if every touched pool has room after the
// same-cycle release, and keeps a sticky underflow flag.
// Assumes non-zero pools are disjoint and configuration precedes traffic.
module rename_pool_tracker #(
    parameter int NUM_POOLS = 3,
    parameter int NUM_REGS  = 16,
    parameter int DST_SLOTS = 2,
    parameter int CNT_W     = 6,
    parameter int COST_W    = 2,
    parameter int RW        = rpt_pkg::idx_w(NUM_REGS),
    parameter int PW        = rpt_pkg::idx_w(NUM_POOLS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_reg_we,
    input  logic [RW-1:0]                    cfg_reg_idx,
    input  logic [NUM_POOLS-1:0]             cfg_reg_mask,
    input  logic [COST_W-1:0]                cfg_reg_cost,
    input  logic                             cfg_cap_we,
    input  logic [PW-1:0]                    cfg_cap_idx,
    input  logic [CNT_W-1:0]                 cfg_cap_val,
    input  logic [DST_SLOTS-1:0]             qry_valid,
    input  logic [DST_SLOTS-1:0][RW-1:0]     qry_reg,
    output logic [NUM_POOLS-1:0]             qry_full,
    input  logic                             alloc_valid,
    input  logic [RW-1:0]                    alloc_reg,
    output logic                             alloc_grant,
    input  logic                             rel_valid,
    input  logic [RW-1:0]                    rel_reg,
    output logic [NUM_POOLS*CNT_W-1:0]       used_cnt,
    output logic                             err_underflow
);
    localparam int NP = NUM_POOLS;

    logic [NUM_REGS-1:0][NP-1:0]     mask_tab;
    logic [NUM_REGS-1:0][COST_W-1:0] cost_tab;
    logic [NP-1:0][CNT_W-1:0]        cap_tab;
    logic [NP-1:0][CNT_W-1:0]        used_arr;
    logic [NP-1:0]                   fits_vec;
    logic [NP-1:0]                   under_vec;

    rpt_cfg_table #(
        .NP(NP), .NR(NUM_REGS), .COST_W(COST_W), .CNT_W(CNT_W), .RW(RW), .PW(PW)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(cfg_reg_we), .reg_idx(cfg_reg_idx),
        .reg_mask(cfg_reg_mask), .reg_cost(cfg_reg_cost),
        .cap_we(cfg_cap_we), .cap_idx(cfg_cap_idx), .cap_val(cfg_cap_val),
        .mask_tab(mask_tab), .cost_tab(cost_tab), .cap_tab(cap_tab)
    );

    for (genvar p = 0; p < NP; p++) begin : g_ctr
        logic [COST_W-1:0] rel_amt;
        logic [COST_W-1:0] alloc_amt;

        // Per-pool charge and refund derived from the register tables.
        always_comb begin
            rel_amt   = (rel_valid && mask_tab[rel_reg][p]) ? cost_tab[rel_reg] : '0;
            alloc_amt = (alloc_valid && mask_tab[alloc_reg][p]) ? cost_tab[alloc_reg] : '0;
        end

        rpt_pool_ctr #(.CNT_W(CNT_W), .COST_W(COST_W)) ctr_i (
            .clk(clk), .rst_n(rst_n), .cap(cap_tab[p]),
            .rel_amt(rel_amt), .alloc_amt(alloc_amt), .alloc_do(alloc_grant),
            .used(used_arr[p]), .fits(fits_vec[p]), .underflow(under_vec[p])
        );
    end

    assign alloc_grant = alloc_valid && (&fits_vec);
    assign used_cnt    = used_arr;

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_underflow <= 1'b0;
        else        err_underflow <= err_underflow | (|under_vec);
    end

    rpt_query #(
        .NP(NP), .NR(NUM_REGS), .ND(DST_SLOTS), .COST_W(COST_W), .CNT_W(CNT_W), .RW(RW)
    ) qry_i (
        .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_reg(qry_reg),
        .mask_tab(mask_tab), .cost_tab(cost_tab), .cap_tab(cap_tab),
        .used(used_arr), .full(qry_full)
    );

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    assert_refuse_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !alloc_grant && !rel_valid) |=> $stable(used_cnt));
endmodule

// File: tb/rename_pool_tracker_tb_top.sv
// Self-checking bench: 3 pools, 8 registers, 2 query slots, 4-bit counts.
module rename_pool_tracker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 3, NR = 8, ND = 2, CW = 4, KW = 2, RW = 3, PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_reg_we = 1'b0;
    logic [RW-1:0] cfg_reg_idx = '0;
    logic [NP-1:0] cfg_reg_mask = '0;
    logic [KW-1:0] cfg_reg_cost = '0;
    logic cfg_cap_we = 1'b0;
    logic [PW-1:0] cfg_cap_idx = '0;
    logic [CW-1:0] cfg_cap_val = '0;
    logic [ND-1:0] qry_valid = '0;
    logic [ND-1:0][RW-1:0] qry_reg = '0;
    logic [NP-1:0] qry_full;
    logic alloc_valid = 1'b0;
    logic [RW-1:0] alloc_reg = '0;
    logic alloc_grant;
    logic rel_valid = 1'b0;
    logic [RW-1:0] rel_reg = '0;
    logic [NP*CW-1:0] used_cnt;
    logic err_underflow;

    int checks = 0, errors = 0;
    int m_mask[NR], m_cost[NR], m_cap[NP], m_used[NP], m_err;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_pool_tracker #(
        .NUM_POOLS(NP), .NUM_REGS(NR), .DST_SLOTS(ND), .CNT_W(CW), .COST_W(KW)
    ) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_full(input int v, input int r0, input int r1);
        int res = 0;
        for (int p = 0; p < NP; p++) begin
            int dem = 0;
            if (v[0] && m_mask[r0][p]) dem += m_cost[r0];
            if (v[1] && m_mask[r1][p]) dem += m_cost[r1];
            if (m_cap[p] != 0 && m_used[p] + dem > m_cap[p]) res |= (1 << p);
        end
        return res;
    endfunction

    // R10: pool p occupies bits [p*CW +: CW].
    task automatic chk_state(input string req);
        for (int p = 0; p < NP; p++)
            chk({req, " count"}, int'(used_cnt[p*CW +: CW]), m_used[p]);
        chk({req, " R8 err"}, int'(err_underflow), m_err);
    endtask

    // One cycle of traffic with the model advanced alongside.
    task automatic step(input int av, input int ar, input int rv, input int rr,
                        input int qv, input int q0, input int q1, input string req);
        int after[NP];
        int fits = 1;
        int g;
        @(negedge clk);
        alloc_valid = av[0]; alloc_reg = RW'(ar);
        rel_valid = rv[0]; rel_reg = RW'(rr);
        qry_valid = ND'(qv); qry_reg[0] = RW'(q0); qry_reg[1] = RW'(q1);
        #1;
        chk({req, " R6 qry_full"}, int'(qry_full), exp_full(qv, q0, q1));
        for (int p = 0; p < NP; p++) begin
            int rel = (rv != 0 && m_mask[rr][p]) ? m_cost[rr] : 0;
            int al  = (av != 0 && m_mask[ar][p]) ? m_cost[ar] : 0;
            if (rel > m_used[p]) begin after[p] = 0; m_err = 1; end
            else after[p] = m_used[p] - rel;
            if (m_cap[p] != 0 && after[p] + al > m_cap[p]) fits = 0;
        end
        g = (av != 0) && fits;
        chk({req, " R3/R9 grant"}, int'(alloc_grant), g);
        for (int p = 0; p < NP; p++) begin
            int al = (av != 0 && m_mask[ar][p]) ? m_cost[ar] : 0;
            m_used[p] = g ? ((after[p] + al > 15) ? 15 : after[p] + al) : after[p];
        end
        @(posedge clk); #1;
        alloc_valid = 1'b0; rel_valid = 1'b0; qry_valid = '0;
        chk_state(req);
    endtask

    task automatic cfg_reg(input int idx, input int mask, input int cost);
        @(negedge clk);
        cfg_reg_we = 1'b1; cfg_reg_idx = RW'(idx);
        cfg_reg_mask = NP'(mask); cfg_reg_cost = KW'(cost);
        @(negedge clk);
        cfg_reg_we = 1'b0;
        m_mask[idx] = mask | 1;   // R4: pool 0 always included
        m_cost[idx] = cost;
    endtask

    task automatic cfg_cap(input int idx, input int val);
        @(negedge clk);
        cfg_cap_we = 1'b1; cfg_cap_idx = PW'(idx); cfg_cap_val = CW'(val);
        @(negedge clk);
        cfg_cap_we = 1'b0;
        m_cap[idx] = val;
    endtask

    // Exhaustive query sweep: every valid pattern and register pair.
    task automatic sweep(input string req);
        for (int v = 0; v < 4; v++)
            for (int a = 0; a < NR; a++)
                for (int b = 0; b < NR; b++) begin
                    @(negedge clk);
                    qry_valid = ND'(v); qry_reg[0] = RW'(a); qry_reg[1] = RW'(b);
                    #1;
                    chk({req, " R6 sweep"}, int'(qry_full), exp_full(v, a, b));
                end
        qry_valid = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_mask[i] = 1; m_cost[i] = 1; end
        for (int p = 0; p < NP; p++) begin m_cap[p] = 0; m_used[p] = 0; end
        m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk_state("R1 reset");
        sweep("R1 R2 reset");

        // Pools: 1 holds regs 0-3, 2 holds regs 4-5. Reg 4 omits bit 0 (R4).
        for (int r = 0; r < NR; r++) begin
            int mk = (r < 4) ? 3 : (r == 4) ? 4 : (r == 5) ? 5 : 1;
            cfg_reg(r, mk, (r % 3) + 1);
        end
        cfg_cap(0, 12); cfg_cap(1, 5); cfg_cap(2, 4);
        sweep("R6 configured");

        step(1, 2, 0, 0, 1, 2, 0, "R3 alloc r2");
        step(1, 1, 0, 0, 3, 0, 1, "R3 alloc r1 fills pool1");
        step(1, 0, 0, 0, 1, 0, 0, "R9 refused r0");
        step(1, 0, 1, 1, 0, 0, 0, "R7 release then alloc");
        step(1, 4, 0, 0, 0, 0, 0, "R4 forced pool0");
        step(0, 0, 1, 2, 0, 0, 0, "R5 release r2");
        step(0, 0, 1, 5, 0, 0, 0, "R8 underflow");
        step(0, 0, 0, 0, 0, 0, 0, "R8 sticky");

        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(int'(lfsr[0] | lfsr[1]), int'(lfsr[4:2]), int'(lfsr[5] & lfsr[6]),
                 int'(lfsr[9:7]), int'(lfsr[11:10]), int'(lfsr[14:12]),
                 int'({lfsr[15], lfsr[1:0]}), "R3 R5 R7 mixed");
        end
        sweep("R6 after traffic");

        // Pool 0 unbounded: saturating count, never full.
        cfg_cap(0, 0);
        for (int i = 0; i < 20; i++) step(1, 6, 0, 0, 1, 7, 0, "R2 saturate");
        sweep("R2 unbounded pool0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule